// File: doc/BRIEF.md
# Write-Protect Status Register

This block keeps the status byte of a serial nonvolatile memory. The byte holds a write-enable latch, a write-in-progress flag, a two-bit block-protect code and a protect-enable bit that arms the hardware protect pin. The block takes decoded command strobes from the command decoder: set latch, clear latch, commit a status write with its data byte, and commit an array write with its byte address. It also takes the active-low protect pin and a pulse that marks the end of the internal write cycle. It returns the status byte for read-out and two permit flags. Each permit flag says whether a write to its target would be accepted right now.

The permit flags are combinational over the stored state, the pin and the presented address. A commit request is accepted only when its permit flag is high in the cycle the request is sampled. An accepted commit starts the write cycle by raising the in-progress flag. The completion pulse ends the cycle and drops the latch. The protect bits sit in ordinary flops that are cleared only by the block reset.

Top module: `wpsr_ctrl`

## Requirements
- R1: During and right after reset, `status_o` reads 8'h00, and both `sr_permit_o` and `arr_permit_o` are low.
- R2: When idle, the status byte reads bit 7 = protect-enable, bits 6..4 = 0, bits 3..2 = block-protect code, bit 1 = write-enable latch, bit 0 = 0. While a write cycle is in progress it reads 8'hFF.
- R3: `wel_set_i` sets the latch at the next edge and `wel_clr_i` clears it. When both are high together, the clear wins.
- R4: The block-protect code guards the array as follows: 00 guards nothing, 01 guards 0x600..0x7FF, 10 guards 0x400..0x7FF, and 11 guards the whole array. `arr_permit_o` is never high for a guarded address.
- R5: `arr_permit_o` is high exactly when the latch is set, no write is in progress and the address is unguarded, whatever the pin and protect-enable are.
- R6: Hardware protection is active when `wp_n_i` is low and protect-enable is 1. `sr_permit_o` is high exactly when the latch is set, no write is in progress and hardware protection is inactive.
- R7: An accepted status write loads protect-enable from data bit 7 and the protect code from data bits 3..2, ignores the other data bits, and starts a write cycle. A refused status write changes nothing.
- R8: An accepted array write starts a write cycle. A refused array write changes nothing.
- R9: `wr_done_i` during a write cycle clears both the in-progress flag and the latch at the next edge, overriding a simultaneous set. When no cycle is in progress, `wr_done_i` has no effect.
- R10: A commit is judged on the state stored before the edge, so a latch set in the same cycle as a request does not enable that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all state |
| wel_set_i | input | 1 | Strobe: set write-enable latch |
| wel_clr_i | input | 1 | Strobe: clear write-enable latch |
| sr_wr_req_i | input | 1 | Strobe: commit status write |
| sr_wr_data_i | input | 8 | Data byte for a status write |
| arr_wr_req_i | input | 1 | Strobe: commit array write |
| arr_addr_i | input | ADDR_W | Byte address of the array write |
| wp_n_i | input | 1 | Hardware protect pin, active low |
| wr_done_i | input | 1 | Pulse: internal write cycle finished |
| status_o | output | 8 | Status byte for read-out |
| sr_permit_o | output | 1 | Status write would be accepted now |
| arr_permit_o | output | 1 | Array write to `arr_addr_i` would be accepted now |

## Verification
The bench probes the address boundaries of each protect code, such as 0x5FF versus 0x600. A design with an off-by-one range would grant or refuse a write at the wrong byte. It drives a set strobe together with a commit. A design that judged the commit on the next state would accept a write that should be refused. It also sends status data with the reserved bits high, and a completion pulse against a simultaneous set or while idle. Wrong handling shows as stray ones in the byte, a latch that survives the end of a cycle, or a latch cleared with no cycle running. Random traffic with a fixed seed then sweeps every combination of pin, protect-enable and latch state against a bench model.

// File: rtl/wpsr_pkg.sv
// Package: shared state type and status byte formatting for the
// write-protect status register. Assumes an 8-bit status byte.
package wpsr_pkg;

    localparam int STATUS_W = 8;
    localparam int BP_W     = 2;

    // Stored status state
    typedef struct packed {
        logic            wpen;
        logic [BP_W-1:0] bp;
        logic            wel;
        logic            wip;
    } sr_state_t;

    // Build the externally visible byte from stored state
    function automatic logic [STATUS_W-1:0] format_status(input sr_state_t s);
        logic [STATUS_W-1:0] b;
        if (s.wip) begin
            b = '1;
        end else begin
            b = {s.wpen, 3'b000, s.bp, s.wel, 1'b0};
        end
        return b;
    endfunction

endpackage

// File: rtl/wpsr_range_map.sv
// Module: maps a block-protect code and a byte address to a guarded flag.
// Code 0 guards nothing, 1 the top quarter, 2 the top half, 3 everything.
// Assumes a power-of-two array of 2**ADDR_W bytes.
module wpsr_range_map #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              guarded_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NCODE = 4;

    logic [NCODE-1:0] in_range;
    logic [ADDR_W:0]  addr_ext;

    assign addr_ext = {1'b0, addr_i};

    // One comparator per protect code, bound computed from the depth
    for (genvar g = 0; g < NCODE; g++) begin : g_code
        if (g == 0) begin : g_none
            assign in_range[g] = 1'b0;
        end else begin : g_bound
            localparam int LOW_INT = (g == 1) ? (DEPTH - DEPTH / 4)
                                   : (g == 2) ? (DEPTH / 2) : 0;
            localparam logic [ADDR_W:0] LOW = LOW_INT[ADDR_W:0];
            assign in_range[g] = (addr_ext >= LOW);
        end
    end

    // Select the comparator for the stored code
    assign guarded_o = in_range[bp_i];

endmodule

// File: rtl/wpsr_permit.sv
// Module: decision table for write permission. Works only on the stored
// state, the protect pin and the presented address, so a request is
// judged on the state that exists before the commit edge.
module wpsr_permit #(
    parameter int ADDR_W = 11
) (
    input  wpsr_pkg::sr_state_t st_i,
    input  logic                wp_n_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                sr_ok_o,
    output logic                arr_ok_o
);
    logic guarded;
    logic hw_lock;
    logic may_write;

    wpsr_range_map #(.ADDR_W(ADDR_W)) u_map (
        .bp_i      (st_i.bp),
        .addr_i    (addr_i),
        .guarded_o (guarded)
    );

    // Combine latch, busy flag, pin and protect map into permits
    always_comb begin
        hw_lock   = st_i.wpen & ~wp_n_i;
        may_write = st_i.wel & ~st_i.wip;
        sr_ok_o   = may_write & ~hw_lock;
        arr_ok_o  = may_write & ~guarded;
    end

endmodule

// File: rtl/wpsr_state.sv
// Module: status register flops and their next-state logic. Commits
// arrive already qualified by the permit logic. All bits, including the
// ones that stand in for nonvolatile cells, clear on the synchronous reset.
module wpsr_state (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wel_set_i,
    input  logic                wel_clr_i,
    input  logic                sr_commit_i,
    input  logic [7:0]          sr_data_i,
    input  logic                arr_commit_i,
    input  logic                done_i,
    output wpsr_pkg::sr_state_t st_o
);
    import wpsr_pkg::*;

    sr_state_t st_q;
    sr_state_t st_d;
    logic      cycle_end;
    logic      unused_data;

    assign unused_data = ^{sr_data_i[6:4], sr_data_i[1:0]};

    // Next-state: completion first, then latch strobes, then commits
    always_comb begin
        st_d      = st_q;
        cycle_end = st_q.wip & done_i;
        if (cycle_end) begin
            st_d.wip = 1'b0;
            st_d.wel = 1'b0;
        end else if (wel_clr_i) begin
            st_d.wel = 1'b0;
        end else if (wel_set_i) begin
            st_d.wel = 1'b1;
        end
        if (sr_commit_i) begin
            st_d.wpen = sr_data_i[7];
            st_d.bp   = sr_data_i[3:2];
        end
        if (sr_commit_i || arr_commit_i) begin
            st_d.wip = 1'b1;
        end
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/wpsr_ctrl.sv
// Module: top of the write-protect status register. Gates commit strobes
// with the permit flags and presents the status byte. Assumes strobes are
// single-cycle pulses from the command decoder.
module wpsr_ctrl #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              sr_wr_req_i,
    input  logic [7:0]        sr_wr_data_i,
    input  logic              arr_wr_req_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              wp_n_i,
    input  logic              wr_done_i,
    output logic [7:0]        status_o,
    output logic              sr_permit_o,
    output logic              arr_permit_o
);
    import wpsr_pkg::*;

    sr_state_t st;
    logic      sr_ok;
    logic      arr_ok;
    logic      sr_commit;
    logic      arr_commit;

    wpsr_permit #(.ADDR_W(ADDR_W)) u_permit (
        .st_i     (st),
        .wp_n_i   (wp_n_i),
        .addr_i   (arr_addr_i),
        .sr_ok_o  (sr_ok),
        .arr_ok_o (arr_ok)
    );

    // Qualify requests with the permits of the current state
    always_comb begin
        sr_commit  = sr_wr_req_i  & sr_ok;
        arr_commit = arr_wr_req_i & arr_ok;
    end

    wpsr_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .wel_set_i    (wel_set_i),
        .wel_clr_i    (wel_clr_i),
        .sr_commit_i  (sr_commit),
        .sr_data_i    (sr_wr_data_i),
        .arr_commit_i (arr_commit),
        .done_i       (wr_done_i),
        .st_o         (st)
    );

    // Drive outputs
    assign status_o     = format_status(st);
    assign sr_permit_o  = sr_ok;
    assign arr_permit_o = arr_ok;

endmodule

// File: rtl/wpsr_ctrl_chk.sv
// Module: property checker for wpsr_ctrl, attached by bind. Observes ports only.
module wpsr_ctrl_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wel_set_i,
    input logic              wel_clr_i,
    input logic              sr_wr_req_i,
    input logic              arr_wr_req_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic              wp_n_i,
    input logic              wr_done_i,
    input logic [7:0]        status_o,
    input logic              sr_permit_o,
    input logic              arr_permit_o
);
    logic unused_chk;
    assign unused_chk = ^{wel_set_i, wel_clr_i, arr_addr_i};

    assert_busy_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> status_o == 8'hFF);

    assert_full_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[0] && status_o[3:2] == 2'b11) |-> !arr_permit_o);

    assert_permit_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_permit_o || sr_permit_o) |-> (status_o[1] && !status_o[0]));

    assert_hw_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[0] && status_o[7] && !wp_n_i) |-> !sr_permit_o);

    assert_refused_sr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[0] && sr_wr_req_i && !sr_permit_o && !(arr_wr_req_i && arr_permit_o))
        |=> status_o[7:2] == $past(status_o[7:2]));

    assert_grant_starts_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_req_i && arr_permit_o) |=> status_o[0]);

    assert_done_ends_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && wr_done_i) |=> status_o[1:0] == 2'b00);

endmodule

bind wpsr_ctrl wpsr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wel_set_i    (wel_set_i),
    .wel_clr_i    (wel_clr_i),
    .sr_wr_req_i  (sr_wr_req_i),
    .arr_wr_req_i (arr_wr_req_i),
    .arr_addr_i   (arr_addr_i),
    .wp_n_i       (wp_n_i),
    .wr_done_i    (wr_done_i),
    .status_o     (status_o),
    .sr_permit_o  (sr_permit_o),
    .arr_permit_o (arr_permit_o)
);

// File: tb/wpsr_ctrl_test.sv
module wpsr_ctrl_test;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wel_set = 1'b0, wel_clr = 1'b0, sr_req = 1'b0, arr_req = 1'b0;
    logic          wp_n = 1'b1, done = 1'b0;
    logic [7:0]    sr_data = '0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    status;
    logic          sr_ok, arr_ok;

    int n_chk = 0;
    int n_fail = 0;

    logic       m_wpen = 1'b0, m_wel = 1'b0, m_wip = 1'b0;
    logic [1:0] m_bp = 2'b00;

    always #2 clk = ~clk;

    wpsr_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
        .sr_wr_req_i(sr_req), .sr_wr_data_i(sr_data), .arr_wr_req_i(arr_req),
        .arr_addr_i(addr), .wp_n_i(wp_n), .wr_done_i(done),
        .status_o(status), .sr_permit_o(sr_ok), .arr_permit_o(arr_ok)
    );

    function automatic logic guarded(input logic [1:0] bp, input logic [AW-1:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 11'h600;
            2'b10:   return a >= 11'h400;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return m_wip ? 8'hFF : {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive, check outputs against model, advance model
    task automatic step(input logic s, input logic c, input logic sq, input logic [7:0] d,
                        input logic aq, input logic [AW-1:0] a, input logic wpn, input logic dn);
        logic g_sr, g_arr, e_sr, e_arr;
        @(negedge clk);
        wel_set = s; wel_clr = c; sr_req = sq; sr_data = d;
        arr_req = aq; addr = a; wp_n = wpn; done = dn;
        #1;
        e_sr  = m_wel & ~m_wip & ~(m_wpen & ~wpn);
        e_arr = m_wel & ~m_wip & ~guarded(m_bp, a);
        check8("R2", status, exp_status());
        check8("R6", {7'd0, sr_ok}, {7'd0, e_sr});
        if (m_wel && !m_wip && guarded(m_bp, a)) check8("R4", {7'd0, arr_ok}, 8'd0);
        else check8("R5", {7'd0, arr_ok}, {7'd0, e_arr});
        @(posedge clk);
        g_sr  = sq & e_sr;
        g_arr = aq & e_arr;
        if (m_wip && dn) begin
            m_wip = 1'b0; m_wel = 1'b0;
        end else if (c) m_wel = 1'b0;
        else if (s) m_wel = 1'b1;
        if (g_sr) begin
            m_wpen = d[7]; m_bp = d[3:2];
        end
        if (g_sr || g_arr) m_wip = 1'b1;
        #1;
        wel_set = 0; wel_clr = 0; sr_req = 0; arr_req = 0; done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(posedge clk);
        #1;
        check8("R1", status, 8'h00);
        check8("R1", {6'd0, sr_ok, arr_ok}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        step(0,0,0,8'h00,1,11'h000,1,0); check8("R8", status, 8'h00);
        step(0,0,1,8'hFC,0,11'h000,1,0); check8("R7", status, 8'h00);
        step(1,0,0,8'h00,1,11'h005,1,0); check8("R10", status, 8'h02);
        step(0,0,1,8'hF4,0,11'h000,1,0); check8("R7", status, 8'hFF);
        step(0,0,0,8'h00,0,11'h000,1,1); check8("R9", status, 8'h84);
        step(0,0,0,8'h00,0,11'h000,1,1); check8("R9", status, 8'h84);
        step(1,0,0,8'h00,0,11'h000,0,0); check8("R3", status, 8'h86);
        step(0,0,1,8'h00,0,11'h000,0,0); check8("R6", status, 8'h86);
        step(0,0,0,8'h00,1,11'h600,0,0); check8("R4", status, 8'h86);
        step(0,0,0,8'h00,1,11'h5FF,0,0); check8("R8", status, 8'hFF);
        step(1,0,0,8'h00,0,11'h000,0,1); check8("R9", status, 8'h84);
        step(1,1,0,8'h00,0,11'h000,1,0); check8("R3", status, 8'h84);
        step(1,0,0,8'h00,0,11'h000,1,0); check8("R3", status, 8'h86);
        step(0,0,1,8'h08,0,11'h000,1,0); check8("R7", status, 8'hFF);
        step(0,0,0,8'h00,0,11'h000,1,1); check8("R7", status, 8'h08);
        step(1,0,0,8'h00,0,11'h3FF,1,0);
        step(0,0,0,8'h00,1,11'h400,1,0); check8("R4", status, 8'h0A);

        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 10) < 3, ($urandom % 10) == 0, ($urandom % 5) == 0,
                 8'($urandom), ($urandom % 5) == 0, AW'($urandom),
                 1'($urandom), ($urandom % 4) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule